// File: doc/BRIEF.md
# Parallel LCD Timing Generator

This block produces the scan timing for a parallel RGB panel: horizontal sync, vertical sync, a data-enable strobe and the column and row index of the pixel being shown. Software sets sync widths, porches and active sizes through a small word-addressed register port. It then brings the output up in three ordered stages: the pixel clock enable, the sync scan and the display data window. Shutting down runs the same stages in reverse. Each stage reports through a status word.

A line is scanned as sync, back porch, active pixels, then front porch. A frame is ordered the same way in lines. The timing words are copied into a working set only at a frame boundary, or while the scan is stopped, so a frame already on the wire is never altered. A clock-enable divider paces the scan. It either passes every source cycle or keeps one in every divider+2 cycles. The chosen output colour format is presented on a port for the downstream formatter.

Top module: `lcd_timing_ctrl`

## Requirements
- R1: After reset all three status bits read 0, de_o, pix_ce_o and both pixel indices are 0, and hsync_o and vsync_o are 0.
- R2: Address 1 holds hsync width−1 in [15:0] and vsync width−1 in [31:16]. Address 2 holds vertical front porch−1 in [15:0] and the vertical back porch as a raw line count (0 allowed) in [31:16]. Address 3 holds horizontal front porch−1 in [15:0] and horizontal back porch−1 in [31:16]. Address 4 holds active width−1 in [15:0] and active height−1 in [31:16].
- R3: While the scan runs, a line is hsync, back porch, active, front porch, and a frame is vsync, back porch, active, front porch. hsync_o/vsync_o are asserted during the sync part. de_o is 1 only inside the active rectangle while the display stage is on. px_x_o/px_y_o give the offset inside it and are 0 elsewhere.
- R4: Address 5 bit 0 inverts hsync_o and bit 1 inverts vsync_o, including the idle level when the scan is stopped.
- R5: Address 5 bits [11:8] appear on fmt_o (0 = 12-bit, 1 = 16-bit, 2 = 18-bit, 3 = 24-bit RGB).
- R6: Address 0 bit 0 set makes pix_ce_o high on every cycle while the pixel-clock stage is on. Otherwise pix_ce_o pulses once every div+2 cycles, with div in address 0 bits [15:8]. pix_ce_o is never high while the pixel-clock stage is off.
- R7: Writing 1s to address 6 starts stages: bit 0 pixel clock, bit 1 sync, bit 2 display. The pixel-clock status sets exactly SETTLE cycles after its command. A sync start is ignored unless the pixel-clock status is set. A display start is ignored unless the sync stage is running.
- R8: Writing 1s to address 7 stops stages with the same bit positions. A pixel-clock stop is ignored while sync runs. A sync stop is ignored while the display stage is on or requested. The display status clears at the next frame end.
- R9: An accepted sync start puts the scan at column 0, row 0 on the next edge. An accepted sync stop lets the current frame finish and halts the scan at its last pixel.
- R10: An accepted display start takes effect at the next frame end, so the display window opens on a whole frame.
- R11: Timing, polarity and format writes made while the scan runs take effect only from the next frame.
- R12: Addresses 0 to 5 read back their stored fields. Address 8 reads status: bit 0 pixel clock, bit 1 sync, bit 2 display.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Source clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 4 | Register word address |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data (combinational from reg_addr) |
| hsync_o | output | 1 | Horizontal sync after polarity |
| vsync_o | output | 1 | Vertical sync after polarity |
| de_o | output | 1 | Data enable |
| px_x_o | output | 16 | Column inside the active area |
| px_y_o | output | 16 | Row inside the active area |
| pix_ce_o | output | 1 | Pixel clock enable |
| fmt_o | output | 4 | Selected output colour format |

## Verification
The assertions assume that register commands arrive only through reg_we. They also assume that reset is held for at least one edge, so the stage states start from zero and later follow the ordering rules alone. The stimulus writes the start and stop registers in every order the requirements name, including commands that must be refused. It changes timing words only through the register port in the middle of a running frame, never by forcing state. The full sweep keeps the pixel clock in pass-through mode, so the bench model can step one position per cycle. The divider is exercised on its own before the scan starts.

// File: rtl/lcd_tc_pkg.sv
package lcd_tc_pkg;

    localparam int FW = 16;
    localparam int AW = 4;
    localparam int DW = 32;

    localparam logic [AW-1:0] A_CLK    = 4'd0;
    localparam logic [AW-1:0] A_SYNCW  = 4'd1;
    localparam logic [AW-1:0] A_VPORCH = 4'd2;
    localparam logic [AW-1:0] A_HPORCH = 4'd3;
    localparam logic [AW-1:0] A_ACTIVE = 4'd4;
    localparam logic [AW-1:0] A_OUTCFG = 4'd5;
    localparam logic [AW-1:0] A_ON     = 4'd6;
    localparam logic [AW-1:0] A_OFF    = 4'd7;
    localparam logic [AW-1:0] A_STAT   = 4'd8;

    typedef struct packed {
        logic [FW-1:0] hsw_m1;
        logic [FW-1:0] vsw_m1;
        logic [FW-1:0] vfp_m1;
        logic [FW-1:0] vbp;
        logic [FW-1:0] hfp_m1;
        logic [FW-1:0] hbp_m1;
        logic [FW-1:0] hact_m1;
        logic [FW-1:0] vact_m1;
        logic          hs_inv;
        logic          vs_inv;
        logic [3:0]    fmt;
    } tcfg_t;

    typedef struct packed {
        logic disp;
        logic sync;
        logic pclk;
    } stat_t;

    function automatic logic [FW+1:0] ext(input logic [FW-1:0] x);
        return {2'b00, x};
    endfunction

endpackage

// File: rtl/lcd_tc_regs.sv
module lcd_tc_regs
    import lcd_tc_pkg::*;
#(
    parameter int DIVW = 8
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            we,
    input  logic [AW-1:0]   addr,
    input  logic [DW-1:0]   wdata,
    input  stat_t           stat,
    output logic [DW-1:0]   rdata,
    output tcfg_t           cfg,
    output logic            bypass,
    output logic [DIVW-1:0] div,
    output logic [2:0]      cmd_on,
    output logic [2:0]      cmd_off
);

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg    <= '0;
            bypass <= 1'b0;
            div    <= '0;
        end else if (we) begin
            case (addr)
                A_CLK: begin
                    bypass <= wdata[0];
                    div    <= wdata[8 +: DIVW];
                end
                A_SYNCW: begin
                    cfg.hsw_m1 <= wdata[FW-1:0];
                    cfg.vsw_m1 <= wdata[DW-1:FW];
                end
                A_VPORCH: begin
                    cfg.vfp_m1 <= wdata[FW-1:0];
                    cfg.vbp    <= wdata[DW-1:FW];
                end
                A_HPORCH: begin
                    cfg.hfp_m1 <= wdata[FW-1:0];
                    cfg.hbp_m1 <= wdata[DW-1:FW];
                end
                A_ACTIVE: begin
                    cfg.hact_m1 <= wdata[FW-1:0];
                    cfg.vact_m1 <= wdata[DW-1:FW];
                end
                A_OUTCFG: begin
                    cfg.hs_inv <= wdata[0];
                    cfg.vs_inv <= wdata[1];
                    cfg.fmt    <= wdata[11:8];
                end
                default: ;
            endcase
        end
    end

    always_comb begin
        rdata = '0;
        case (addr)
            A_CLK: begin
                rdata[0]         = bypass;
                rdata[8 +: DIVW] = div;
            end
            A_SYNCW:  rdata = {cfg.vsw_m1, cfg.hsw_m1};
            A_VPORCH: rdata = {cfg.vbp, cfg.vfp_m1};
            A_HPORCH: rdata = {cfg.hbp_m1, cfg.hfp_m1};
            A_ACTIVE: rdata = {cfg.vact_m1, cfg.hact_m1};
            A_OUTCFG: begin
                rdata[0]    = cfg.hs_inv;
                rdata[1]    = cfg.vs_inv;
                rdata[11:8] = cfg.fmt;
            end
            A_STAT:   rdata[2:0] = {stat.disp, stat.sync, stat.pclk};
            default:  rdata = '0;
        endcase
    end

    assign cmd_on  = (we && addr == A_ON)  ? wdata[2:0] : 3'b000;
    assign cmd_off = (we && addr == A_OFF) ? wdata[2:0] : 3'b000;

endmodule

// File: rtl/lcd_tc_clkdiv.sv
module lcd_tc_clkdiv #(
    parameter int DIVW = 8
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            en,
    input  logic            bypass,
    input  logic [DIVW-1:0] div,
    output logic            ce
);

    localparam int CW = DIVW + 1;

    logic [CW-1:0] cnt;
    logic          at_end;

    assign at_end = (cnt == CW'(div) + CW'(1));
    assign ce     = en && (bypass || at_end);

    always_ff @(posedge clk) begin
        if (rst || !en)
            cnt <= '0;
        else if (at_end)
            cnt <= '0;
        else
            cnt <= cnt + CW'(1);
    end

endmodule

// File: rtl/lcd_tc_seq.sv
module lcd_tc_seq
    import lcd_tc_pkg::*;
#(
    parameter int SETTLE = 4
) (
    input  logic       clk,
    input  logic       rst,
    input  logic [2:0] cmd_on,
    input  logic [2:0] cmd_off,
    input  logic       frame_end,
    output stat_t      st,
    output logic       sync_start
);

    localparam int SW = $clog2(SETTLE + 1);

    logic          pclk_tgt;
    logic          disp_tgt;
    logic          stop_req;
    logic          stop_ok;
    logic [SW-1:0] cnt;

    assign sync_start = cmd_on[1] && !st.sync && st.pclk && pclk_tgt;
    assign stop_ok    = cmd_off[1] && st.sync && !st.disp && !disp_tgt;

    always_ff @(posedge clk) begin
        if (rst) begin
            st       <= '0;
            pclk_tgt <= 1'b0;
            disp_tgt <= 1'b0;
            stop_req <= 1'b0;
            cnt      <= '0;
        end else begin
            if (cmd_on[0])
                pclk_tgt <= 1'b1;
            else if (cmd_off[0] && !st.sync)
                pclk_tgt <= 1'b0;

            if (st.pclk != pclk_tgt) begin
                if (cnt == SW'(SETTLE - 1)) begin
                    st.pclk <= pclk_tgt;
                    cnt     <= '0;
                end else begin
                    cnt <= cnt + SW'(1);
                end
            end else begin
                cnt <= '0;
            end

            if (sync_start)
                st.sync <= 1'b1;
            if (frame_end && stop_req) begin
                st.sync  <= 1'b0;
                stop_req <= 1'b0;
            end else if (stop_ok) begin
                stop_req <= 1'b1;
            end

            if (cmd_on[2] && st.sync && !stop_req)
                disp_tgt <= 1'b1;
            else if (cmd_off[2])
                disp_tgt <= 1'b0;
            if (frame_end)
                st.disp <= disp_tgt;
        end
    end

endmodule

// File: rtl/lcd_tc_scan.sv
module lcd_tc_scan
    import lcd_tc_pkg::*;
(
    input  logic          clk,
    input  logic          rst,
    input  logic          ce,
    input  logic          run,
    input  logic          start,
    input  logic          disp,
    input  tcfg_t         live,
    output logic          hsync,
    output logic          vsync,
    output logic          de,
    output logic [FW-1:0] px_x,
    output logic [FW-1:0] px_y,
    output logic [3:0]    fmt,
    output logic          frame_end
);

    localparam int TW = FW + 2;

    tcfg_t         sh;
    logic [TW-1:0] h, v;
    logic [TW-1:0] hsw, hbeg, hend, htot;
    logic [TW-1:0] vsw, vbeg, vend, vtot;
    logic          h_last, v_last, in_h, in_v;

    always_comb begin
        hsw  = ext(sh.hsw_m1) + TW'(1);
        hbeg = hsw + ext(sh.hbp_m1) + TW'(1);
        hend = hbeg + ext(sh.hact_m1) + TW'(1);
        htot = hend + ext(sh.hfp_m1) + TW'(1);
        vsw  = ext(sh.vsw_m1) + TW'(1);
        vbeg = vsw + ext(sh.vbp);
        vend = vbeg + ext(sh.vact_m1) + TW'(1);
        vtot = vend + ext(sh.vfp_m1) + TW'(1);
    end

    assign h_last    = (h == htot - TW'(1));
    assign v_last    = (v == vtot - TW'(1));
    assign frame_end = run && ce && h_last && v_last;

    always_ff @(posedge clk) begin
        if (rst)
            sh <= '0;
        else if (!run || frame_end)
            sh <= live;
    end

    always_ff @(posedge clk) begin
        if (rst || start) begin
            h <= '0;
            v <= '0;
        end else if (run && ce) begin
            if (h_last) begin
                h <= '0;
                v <= v_last ? '0 : v + TW'(1);
            end else begin
                h <= h + TW'(1);
            end
        end
    end

    assign in_h  = (h >= hbeg) && (h < hend);
    assign in_v  = (v >= vbeg) && (v < vend);
    assign de    = run && disp && in_h && in_v;
    assign hsync = (run && (h < hsw)) ^ sh.hs_inv;
    assign vsync = (run && (v < vsw)) ^ sh.vs_inv;
    assign px_x  = de ? FW'(h - hbeg) : '0;
    assign px_y  = de ? FW'(v - vbeg) : '0;
    assign fmt   = sh.fmt;

endmodule

// File: rtl/lcd_timing_ctrl.sv
module lcd_timing_ctrl
    import lcd_tc_pkg::*;
#(
    parameter int DIVW   = 8,
    parameter int SETTLE = 4
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          reg_we,
    input  logic [3:0]    reg_addr,
    input  logic [31:0]   reg_wdata,
    output logic [31:0]   reg_rdata,
    output logic          hsync_o,
    output logic          vsync_o,
    output logic          de_o,
    output logic [15:0]   px_x_o,
    output logic [15:0]   px_y_o,
    output logic          pix_ce_o,
    output logic [3:0]    fmt_o
);

    tcfg_t           cfg;
    stat_t           st;
    logic            bypass;
    logic [DIVW-1:0] div;
    logic [2:0]      cmd_on, cmd_off;
    logic            frame_end, sync_start;

    lcd_tc_regs #(.DIVW(DIVW)) u_regs (
        .clk(clk), .rst(rst), .we(reg_we), .addr(reg_addr), .wdata(reg_wdata),
        .stat(st), .rdata(reg_rdata), .cfg(cfg), .bypass(bypass), .div(div),
        .cmd_on(cmd_on), .cmd_off(cmd_off)
    );

    lcd_tc_clkdiv #(.DIVW(DIVW)) u_div (
        .clk(clk), .rst(rst), .en(st.pclk), .bypass(bypass), .div(div), .ce(pix_ce_o)
    );

    lcd_tc_seq #(.SETTLE(SETTLE)) u_seq (
        .clk(clk), .rst(rst), .cmd_on(cmd_on), .cmd_off(cmd_off),
        .frame_end(frame_end), .st(st), .sync_start(sync_start)
    );

    lcd_tc_scan u_scan (
        .clk(clk), .rst(rst), .ce(pix_ce_o), .run(st.sync), .start(sync_start),
        .disp(st.disp), .live(cfg), .hsync(hsync_o), .vsync(vsync_o), .de(de_o),
        .px_x(px_x_o), .px_y(px_y_o), .fmt(fmt_o), .frame_end(frame_end)
    );

endmodule

// File: rtl/lcd_timing_ctrl_chk.sv
module lcd_timing_ctrl_chk
    import lcd_tc_pkg::*;
(
    input logic  clk,
    input logic  rst,
    input logic  de,
    input logic  pix_ce,
    input stat_t st,
    input logic  frame_end
);

    p_de_needs_disp_r10: assert property (@(posedge clk) disable iff (rst)
        de |-> st.disp);

    p_disp_opens_at_frame_r10: assert property (@(posedge clk) disable iff (rst)
        $rose(st.disp) |-> $past(frame_end));

    p_sync_needs_pclk_r7: assert property (@(posedge clk) disable iff (rst)
        st.sync |-> st.pclk);

    p_disp_needs_sync_r8: assert property (@(posedge clk) disable iff (rst)
        st.disp |-> st.sync);

    p_sync_stops_at_frame_r9: assert property (@(posedge clk) disable iff (rst)
        $fell(st.sync) |-> $past(frame_end));

    p_pclk_stop_after_sync_r8: assert property (@(posedge clk) disable iff (rst)
        $fell(st.pclk) |-> !st.sync);

    p_ce_gated_r6: assert property (@(posedge clk) disable iff (rst)
        pix_ce |-> st.pclk);

endmodule

bind lcd_timing_ctrl lcd_timing_ctrl_chk u_chk (
    .clk(clk), .rst(rst), .de(de_o), .pix_ce(pix_ce_o), .st(st), .frame_end(frame_end)
);

// File: tb/lcd_timing_ctrl_bench.sv
`timescale 1ns/1ps
module lcd_timing_ctrl_bench;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        reg_we = 1'b0;
    logic [3:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        hsync_o, vsync_o, de_o, pix_ce_o;
    logic [15:0] px_x_o, px_y_o;
    logic [3:0]  fmt_o;

    always #2 clk = ~clk;

    lcd_timing_ctrl u_lcd_timing_ctrl (
        .clk(clk), .rst(rst), .reg_we(reg_we), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .hsync_o(hsync_o),
        .vsync_o(vsync_o), .de_o(de_o), .px_x_o(px_x_o), .px_y_o(px_y_o),
        .pix_ce_o(pix_ce_o), .fmt_o(fmt_o)
    );

    int n_vec = 0, n_bad = 0;
    bit done = 0;

    // bench model
    logic [31:0] m_live [6];
    logic [31:0] m_sh   [6];
    int  mh = 0, mv = 0;
    bit  mrun = 0, mstop = 0, mdisp = 0, mdtgt = 0, mpclk = 0, chk_on = 0;

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_vec++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
        end
    endtask

    function automatic int f_htot();
        return int'(m_sh[1][15:0]) + 1 + int'(m_sh[3][31:16]) + 1 +
               int'(m_sh[4][15:0]) + 1 + int'(m_sh[3][15:0]) + 1;
    endfunction

    function automatic int f_vtot();
        return int'(m_sh[1][31:16]) + 1 + int'(m_sh[2][31:16]) +
               int'(m_sh[4][31:16]) + 1 + int'(m_sh[2][15:0]) + 1;
    endfunction

    task automatic check_outputs();
        int hsw = int'(m_sh[1][15:0]) + 1;
        int vsw = int'(m_sh[1][31:16]) + 1;
        int hb  = hsw + int'(m_sh[3][31:16]) + 1;
        int vb  = vsw + int'(m_sh[2][31:16]);
        int w   = int'(m_sh[4][15:0]) + 1;
        int hh  = int'(m_sh[4][31:16]) + 1;
        bit de_e = mrun && mdisp && mh >= hb && mh < hb + w && mv >= vb && mv < vb + hh;
        chk("R3 R4 hsync", {31'b0, hsync_o}, {31'b0, (mrun && mh < hsw) ^ m_sh[5][0]});
        chk("R3 R4 vsync", {31'b0, vsync_o}, {31'b0, (mrun && mv < vsw) ^ m_sh[5][1]});
        chk("R3 R10 de", {31'b0, de_o}, {31'b0, de_e});
        chk("R3 px_x", {16'b0, px_x_o}, de_e ? 32'(mh - hb) : 32'd0);
        chk("R3 px_y", {16'b0, px_y_o}, de_e ? 32'(mv - vb) : 32'd0);
        chk("R5 R11 fmt", {28'b0, fmt_o}, {28'b0, m_sh[5][11:8]});
    endtask

    task automatic step();
        bit          w  = reg_we;
        logic [3:0]  a  = reg_addr;
        logic [31:0] d  = reg_wdata;
        int  ht = f_htot();
        int  vt = f_vtot();
        bit  wrap  = mrun && mh == ht - 1 && mv == vt - 1;
        bit  start = w && a == 4'd6 && d[1] && !mrun && mpclk;
        bit  stopk = w && a == 4'd7 && d[1] && mrun && !mdisp && !mdtgt;
        bit  don   = w && a == 4'd6 && d[2] && mrun && !mstop;
        bit  doff  = w && a == 4'd7 && d[2];
        bit  ostop = mstop;
        @(posedge clk);
        if (!mrun || wrap) m_sh = m_live;
        if (wrap) mdisp = mdtgt;
        if (start) begin
            mrun = 1; mh = 0; mv = 0;
        end else if (mrun) begin
            if (wrap) begin
                mh = 0; mv = 0;
                if (ostop) begin mrun = 0; mstop = 0; end
            end else if (mh == ht - 1) begin
                mh = 0; mv++;
            end else begin
                mh++;
            end
        end
        if (!(wrap && ostop) && stopk) mstop = 1;
        if (don) mdtgt = 1; else if (doff) mdtgt = 0;
        if (w && a <= 4'd5) m_live[a] = d;
        @(negedge clk);
        if (chk_on) check_outputs();
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) step();
    endtask

    task automatic wr(input logic [3:0] a, input logic [31:0] d);
        reg_we = 1'b1; reg_addr = a; reg_wdata = d;
        step();
        reg_we = 1'b0;
    endtask

    task automatic rd(input string tag, input logic [3:0] a, input logic [31:0] exp);
        reg_addr = a;
        #0.5;
        chk(tag, reg_rdata, exp);
    endtask

    task automatic rd_stat(input string tag);
        rd(tag, 4'd8, {29'b0, mdisp, mrun, mpclk});
    endtask

    task automatic ce_period(input string tag, input int exp);
        int g = 0;
        while (!pix_ce_o && g < 300) begin step(); g++; end
        for (int k = 0; k < 4; k++) begin
            int c = 0;
            do begin step(); c++; end while (!pix_ce_o && c < 300);
            chk(tag, 32'(c), 32'(exp));
        end
    endtask

    initial begin
        for (int i = 0; i < 6; i++) begin m_live[i] = '0; m_sh[i] = '0; end
        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R1 reset state
        rd_stat("R1 status");
        chk("R1 idle outputs", {26'b0, hsync_o, vsync_o, de_o, pix_ce_o, 2'b0}, 32'd0);
        chk("R1 pixel index", {px_y_o, px_x_o}, 32'd0);

        // R2 / R12 programming and readback
        wr(4'd1, 32'h0000_0001);
        wr(4'd2, 32'h0000_0001);
        wr(4'd3, 32'h0002_0000);
        wr(4'd4, 32'h0002_0003);
        wr(4'd5, 32'h0000_0300);
        wr(4'd0, 32'h0000_0100);
        rd("R12 R2 word1", 4'd1, 32'h0000_0001);
        rd("R12 R2 word2", 4'd2, 32'h0000_0001);
        rd("R12 R2 word3", 4'd3, 32'h0002_0000);
        rd("R12 R2 word4", 4'd4, 32'h0002_0003);
        rd("R12 word5", 4'd5, 32'h0000_0300);
        rd("R12 clk word", 4'd0, 32'h0000_0100);

        // R7 refused starts before pixel clock
        wr(4'd6, 32'h2);
        wr(4'd6, 32'h4);
        idle(2);
        rd_stat("R7 refused starts");

        // R7 pixel clock settle time
        wr(4'd6, 32'h1);
        idle(3);
        rd_stat("R7 pclk not yet");
        step();
        mpclk = 1;
        rd_stat("R7 pclk up");

        // R6 divider
        ce_period("R6 div=1", 3);
        wr(4'd0, 32'h0000_0500);
        ce_period("R6 div=5", 7);
        wr(4'd0, 32'h0000_0001);
        for (int k = 0; k < 4; k++) begin
            step();
            chk("R6 bypass", {31'b0, pix_ce_o}, 32'd1);
        end

        // R9 sync start, full frame, display still refused earlier
        chk_on = 1;
        wr(4'd6, 32'h2);
        chk("R9 start origin", {31'b0, hsync_o}, 32'd1);
        idle(65);
        rd_stat("R7 R9 sync running");

        // R10 display start at frame boundary
        wr(4'd6, 32'h4);
        idle(130);
        rd_stat("R10 display on");

        // R11 mid-frame changes
        idle(25);
        wr(4'd4, 32'h0001_0002);
        wr(4'd5, 32'h0000_0103);
        wr(4'd2, 32'h0002_0000);
        wr(4'd3, 32'h0000_0000);
        idle(150);

        // R8 refused stops
        wr(4'd7, 32'h1);
        idle(10);
        rd_stat("R8 pclk stop refused");
        chk("R8 ce still running", {31'b0, pix_ce_o}, 32'd1);
        wr(4'd7, 32'h2);
        idle(90);
        rd_stat("R8 sync stop refused");
        wr(4'd7, 32'h4);
        idle(50);
        rd_stat("R8 display off at frame end");

        // R9 sync stop at frame end
        wr(4'd7, 32'h2);
        idle(50);
        rd_stat("R9 sync stopped");
        chk("R9 idle levels", {29'b0, hsync_o, vsync_o, de_o}, 32'b110);

        // R8 pixel clock stop
        wr(4'd7, 32'h1);
        idle(3);
        rd_stat("R8 pclk still up");
        step();
        mpclk = 0;
        rd_stat("R8 pclk down");
        chk("R8 R6 ce off", {31'b0, pix_ce_o}, 32'd0);

        if (!done) begin
            done = 1;
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end

    initial begin
        #(4 * 150000);
        if (!done) begin
            done = 1;
            n_bad++;
            $display("FAIL watchdog expired actual=hung expected=finished");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end

endmodule